// File: doc/BRIEF.md
# Two-Channel Conversion Sequencer

This block decides when a single shared 12-bit converter samples the supply-voltage channel and when it samples the current-amplifier channel. The converter and its input multiplexer sit outside the block. The block reaches them through a one-cycle start pulse, a channel select, and a done strobe that returns the data. Work is requested in two ways. A command word written by the serial-bus slave can ask for one-shot or continuous conversion on either channel. A rising level on an external convert pin can trigger a single pass.

Each finished conversion is latched into that channel's result register, which holds its value until the next result arrives. Each channel has a valid flag. The serial slave uses it to choose between zero-fill and returning data, and the one-shot bits tell it when to withhold the acknowledge. While the slave is shifting a result out, it holds a per-channel read-busy input high, and the block defers writing that register. The divider-range bit of the command word is passed straight through to the analog front end.

Top module: `conv_seq_ctrl`

## Requirements
- R1: After synchronous reset, both results are 0, both valid flags are 0, `adc_start` is 0, `div_sel` is 0 and both one-shot bits are 0.
- R2: A command write drives `div_sel` to command bit 4 from the next cycle (0 selects the 14:1 divider, 1 selects the 7:2 divider). A write with only bit 4 set starts no conversion.
- R3: Command bit 1 (voltage one-shot) causes exactly one voltage conversion. Afterwards `v_once_busy` returns to 0 and the voltage result is valid. Bit 1 reads back as set until that result is latched.
- R4: When both channels are requested in one pass (bit 1 and bit 3 are the one-shot bits for voltage and current), the voltage conversion is done first and the current conversion second. No new start is issued until both results are latched. `adc_chan` is 0 for voltage and 1 for current.
- R5: Command bits 0 and 2 (voltage and current continuous) keep converting both channels alternately until they are written to 0. After that, no further conversion starts.
- R6: A rising edge on `conv_pin` runs exactly one pass over the channels selected (one-shot or continuous) by the last command write. Holding the pin high does not repeat the pass.
- R7: A command write clears both valid flags. A flag is set again only when its channel's next result is latched.
- R8: While `v_rd_busy` (or `i_rd_busy`) is high, the voltage (or current) result does not change. A completed conversion is written once the busy input drops.
- R9: A command write that lands while a conversion is outstanding, is awaiting its latch, or arrives in the same cycle as `adc_done`, discards that result. The result register is left unchanged and the valid flag stays clear.
- R10: `adc_start` is a single-cycle pulse, and a new start is never issued while a previous conversion has not returned `adc_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command write strobe from the serial slave |
| cmd_data | input | 5 | Command: bit0 V continuous, bit1 V one-shot, bit2 I continuous, bit3 I one-shot, bit4 divider range |
| conv_pin | input | 1 | Asynchronous convert request pin |
| adc_start | output | 1 | One-cycle converter start pulse |
| adc_chan | output | 1 | Multiplexer select: 0 voltage, 1 current |
| adc_done | input | 1 | Converter completion strobe |
| adc_data | input | DATA_W | Converter result, valid with adc_done |
| div_sel | output | 1 | Voltage divider range select |
| v_rd_busy | input | 1 | Voltage result is being shifted out |
| i_rd_busy | input | 1 | Current result is being shifted out |
| v_result | output | DATA_W | Latest voltage result |
| i_result | output | DATA_W | Latest current result |
| v_valid | output | 1 | Voltage result valid since the last command write |
| i_valid | output | 1 | Current result valid since the last command write |
| v_once_busy | output | 1 | Voltage one-shot still pending |
| i_once_busy | output | 1 | Current one-shot still pending |

## Verification
The collision that matters most is a command write landing in the same cycle as the converter's done strobe. In that cycle the sequencer has to choose between latching the data and abandoning the pass. The bench provokes the collision by arming its converter model to issue a new command on the exact edge at which it raises `adc_done`. It judges the outcome by three things: the stale data never appears on the result port, the valid flag stays low, and the fresh request produces a new start whose data is the one finally latched. A slower variant lands the write while a held read keeps the result waiting to be latched.

// File: rtl/convseq_pkg.sv
package convseq_pkg;

    localparam int NUM_CH = 2;
    localparam int CMD_W  = 5;

    typedef enum logic {
        CH_VOLT = 1'b0,
        CH_CURR = 1'b1
    } chan_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_CONV,
        SQ_LATCH
    } seq_st_e;

    // bit order matches the command word: [4] range .. [0] voltage continuous
    typedef struct packed {
        logic range;
        logic i_once;
        logic i_cont;
        logic v_once;
        logic v_cont;
    } mode_t;

    function automatic logic [NUM_CH-1:0] chan_onehot(chan_e c);
        return (c == CH_CURR) ? 2'b10 : 2'b01;
    endfunction

    function automatic logic [NUM_CH-1:0] mode_need(mode_t m);
        return {m.i_cont | m.i_once, m.v_cont | m.v_once};
    endfunction

endpackage

// File: rtl/conv_trig_sync.sv
module conv_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_async,
    output logic pin_rise
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], pin_async};
    end

    assign pin_rise = sh[STAGES-1] & ~sh[STAGES];

endmodule

// File: rtl/conv_mode_reg.sv
module conv_mode_reg
    import convseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_data,
    input  logic              pin_rise,
    input  logic [NUM_CH-1:0] take,
    input  logic [NUM_CH-1:0] done_ch,
    output mode_t             mode,
    output logic [NUM_CH-1:0] need
);
    mode_t             mode_q;
    logic [NUM_CH-1:0] pin_sel;
    logic [NUM_CH-1:0] pin_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            pin_sel <= '0;
            pin_req <= '0;
        end else if (cmd_wr) begin
            mode_q  <= mode_t'(cmd_data);
            pin_sel <= mode_need(mode_t'(cmd_data));
            pin_req <= '0;
        end else begin
            mode_q.v_once <= mode_q.v_once & ~done_ch[0];
            mode_q.i_once <= mode_q.i_once & ~done_ch[1];
            pin_req       <= (pin_req & ~take) | (pin_rise ? pin_sel : '0);
        end
    end

    assign mode = mode_q;
    assign need = mode_need(mode_q) | pin_req;

    // R3
    v_once_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mode_q.v_once) |-> ($past(done_ch[0]) || $past(cmd_wr)));
    // R3
    i_once_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mode_q.i_once) |-> ($past(done_ch[1]) || $past(cmd_wr)));

endmodule

// File: rtl/conv_sched.sv
module conv_sched
    import convseq_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] need,
    input  logic              abort,
    input  logic [NUM_CH-1:0] hold,
    input  logic              adc_done,
    input  logic [DATA_W-1:0] adc_data,
    output logic              adc_start,
    output logic              adc_chan,
    output logic [NUM_CH-1:0] take,
    output logic [NUM_CH-1:0] latch,
    output logic [DATA_W-1:0] wr_data
);
    seq_st_e           st;
    chan_e             chan_q;
    logic [NUM_CH-1:0] pass_q;
    logic              stale_q;
    logic              start_q;
    logic [DATA_W-1:0] pend_q;
    logic              hold_cur;

    assign hold_cur = (chan_q == CH_CURR) ? hold[1] : hold[0];
    assign take     = (st == SQ_IDLE && !abort) ? need : '0;
    assign latch    = (st == SQ_LATCH && !abort && !hold_cur) ? chan_onehot(chan_q) : '0;
    assign wr_data  = pend_q;
    assign adc_start = start_q;
    assign adc_chan  = chan_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SQ_IDLE;
            chan_q  <= CH_VOLT;
            pass_q  <= '0;
            stale_q <= 1'b0;
            start_q <= 1'b0;
            pend_q  <= '0;
        end else begin
            start_q <= 1'b0;
            unique case (st)
                SQ_IDLE: begin
                    if (!abort && need != '0) begin
                        pass_q  <= need;
                        chan_q  <= need[0] ? CH_VOLT : CH_CURR;
                        start_q <= 1'b1;
                        stale_q <= 1'b0;
                        st      <= SQ_CONV;
                    end
                end
                SQ_CONV: begin
                    if (adc_done) begin
                        if (stale_q || abort) begin
                            stale_q <= 1'b0;
                            st      <= SQ_IDLE;
                        end else begin
                            pend_q <= adc_data;
                            st     <= SQ_LATCH;
                        end
                    end else if (abort) begin
                        stale_q <= 1'b1;
                    end
                end
                SQ_LATCH: begin
                    if (abort) begin
                        st <= SQ_IDLE;
                    end else if (!hold_cur) begin
                        if (chan_q == CH_VOLT && pass_q[1]) begin
                            chan_q  <= CH_CURR;
                            start_q <= 1'b1;
                            st      <= SQ_CONV;
                        end else begin
                            st <= SQ_IDLE;
                        end
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    logic outst;
    always_ff @(posedge clk) begin
        if (rst)           outst <= 1'b0;
        else if (adc_start) outst <= 1'b1;
        else if (adc_done)  outst <= 1'b0;
    end

    // R10
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        adc_start |=> !adc_start);
    // R10
    one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
        adc_start |-> !outst);

endmodule

// File: rtl/conv_result_bank.sv
module conv_result_bank
    import convseq_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          clr,
    input  logic [NUM_CH-1:0]             latch,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [NUM_CH-1:0][DATA_W-1:0] res,
    output logic [NUM_CH-1:0]             valid
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                res[g]   <= '0;
                valid[g] <= 1'b0;
            end else begin
                if (latch[g]) res[g] <= wr_data;
                if (clr)           valid[g] <= 1'b0;
                else if (latch[g]) valid[g] <= 1'b1;
            end
        end

        // R7
        valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(valid[g]) |-> $past(latch[g]));
    end

endmodule

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl
    import convseq_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic [4:0]        cmd_data,
    input  logic              conv_pin,
    output logic              adc_start,
    output logic              adc_chan,
    input  logic              adc_done,
    input  logic [DATA_W-1:0] adc_data,
    output logic              div_sel,
    input  logic              v_rd_busy,
    input  logic              i_rd_busy,
    output logic [DATA_W-1:0] v_result,
    output logic [DATA_W-1:0] i_result,
    output logic              v_valid,
    output logic              i_valid,
    output logic              v_once_busy,
    output logic              i_once_busy
);
    logic                          pin_rise;
    mode_t                         mode;
    logic [NUM_CH-1:0]             need, take, latch, valid;
    logic [DATA_W-1:0]             wr_data;
    logic [NUM_CH-1:0][DATA_W-1:0] res;
    logic [NUM_CH-1:0]             hold;

    assign hold = {i_rd_busy, v_rd_busy};

    conv_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pin_async(conv_pin), .pin_rise(pin_rise)
    );

    conv_mode_reg u_mode (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
        .pin_rise(pin_rise), .take(take), .done_ch(latch),
        .mode(mode), .need(need)
    );

    conv_sched #(.DATA_W(DATA_W)) u_sched (
        .clk(clk), .rst(rst), .need(need), .abort(cmd_wr), .hold(hold),
        .adc_done(adc_done), .adc_data(adc_data), .adc_start(adc_start),
        .adc_chan(adc_chan), .take(take), .latch(latch), .wr_data(wr_data)
    );

    conv_result_bank #(.DATA_W(DATA_W)) u_bank (
        .clk(clk), .rst(rst), .clr(cmd_wr), .latch(latch),
        .wr_data(wr_data), .res(res), .valid(valid)
    );

    assign div_sel     = mode.range;
    assign v_once_busy = mode.v_once;
    assign i_once_busy = mode.i_once;
    assign v_result    = res[0];
    assign i_result    = res[1];
    assign v_valid     = valid[0];
    assign i_valid     = valid[1];

    // R2
    div_follow_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |=> div_sel == $past(cmd_data[4]));
    // R7
    valid_clr_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |=> (!v_valid && !i_valid));
    // R8
    v_hold_chk: assert property (@(posedge clk) disable iff (rst)
        v_rd_busy |=> $stable(v_result));
    // R8
    i_hold_chk: assert property (@(posedge clk) disable iff (rst)
        i_rd_busy |=> $stable(i_result));

endmodule

// File: tb/sim_conv_seq_ctrl.sv
module sim_conv_seq_ctrl;
    localparam int DW  = 12;
    localparam int LAT = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_wr = 1'b0;
    logic [4:0]    cmd_data = '0;
    logic          conv_pin = 1'b0;
    logic          adc_start, adc_chan;
    logic          adc_done = 1'b0;
    logic [DW-1:0] adc_data = '0;
    logic          div_sel;
    logic          v_rd_busy = 1'b0, i_rd_busy = 1'b0;
    logic [DW-1:0] v_result, i_result;
    logic          v_valid, i_valid, v_once_busy, i_once_busy;

    always #4 clk = ~clk;

    conv_seq_ctrl #(.DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
        .conv_pin(conv_pin), .adc_start(adc_start), .adc_chan(adc_chan),
        .adc_done(adc_done), .adc_data(adc_data), .div_sel(div_sel),
        .v_rd_busy(v_rd_busy), .i_rd_busy(i_rd_busy),
        .v_result(v_result), .i_result(i_result),
        .v_valid(v_valid), .i_valid(i_valid),
        .v_once_busy(v_once_busy), .i_once_busy(i_once_busy)
    );

    int n_chk = 0, n_err = 0;
    logic [DW:0] res_q[$];
    logic        exp_ch_q[$];
    bit          chk_order = 1'b0;
    bit          cmd_req = 1'b0;
    logic [4:0]  cmd_val = '0;
    bit          collide_arm = 1'b0;
    logic [4:0]  collide_val = '0;
    bit          outst = 1'b0, discard = 1'b0;
    logic        cur_ch = 1'b0;
    int          cnt = 0;
    logic [7:0]  seq = 8'd1;
    int          n_start = 0, n_vs = 0, n_is = 0;
    logic [DW-1:0] prev_v = '0, prev_i = '0;

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // scoreboard monitor, converter model and command driver in one ordered process
    always @(negedge clk) begin
        if (!rst) begin
            logic [DW:0] e;
            adc_done = 1'b0;
            cmd_wr   = 1'b0;
            if (v_result !== prev_v) begin
                if (res_q.size() == 0) check("R8 unexpected v_result", int'(v_result), -1);
                else begin e = res_q.pop_front(); check("R3 v_result", int'({1'b0, v_result}), int'(e)); end
                prev_v = v_result;
            end
            if (i_result !== prev_i) begin
                if (res_q.size() == 0) check("R8 unexpected i_result", int'(i_result), -1);
                else begin e = res_q.pop_front(); check("R4 i_result", int'({1'b1, i_result}), int'(e)); end
                prev_i = i_result;
            end
            if (outst) begin
                cnt--;
                if (cnt == 0) begin
                    outst    = 1'b0;
                    adc_done = 1'b1;
                    adc_data = {(cur_ch ? 4'hA : 4'h3), seq};
                    seq++;
                    if (collide_arm) begin
                        cmd_req = 1'b1; cmd_val = collide_val; collide_arm = 1'b0;
                    end
                    if (!(discard || cmd_req)) res_q.push_back({cur_ch, adc_data});
                    discard = 1'b0;
                end
            end
            if (adc_start) begin
                n_start++;
                if (adc_chan) n_is++; else n_vs++;
                if (outst) check("R10 start while outstanding", 1, 0);
                outst = 1'b1; cnt = LAT; cur_ch = adc_chan;
                if (chk_order) begin
                    if (exp_ch_q.size() == 0) check("R4 unexpected start", int'(adc_chan), -1);
                    else check("R4 start channel order", int'(adc_chan), int'(exp_ch_q.pop_front()));
                end
            end
            if (cmd_req) begin
                cmd_wr = 1'b1; cmd_data = cmd_val; cmd_req = 1'b0;
                res_q.delete();
                if (outst) discard = 1'b1;
            end
        end
    end

    task automatic do_cmd(logic [4:0] v);
        cmd_val = v; cmd_req = 1'b1;
        do @(negedge clk); while (cmd_req);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        int s;
        logic [DW-1:0] snap;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 v_result", int'(v_result), 0);
        check("R1 i_result", int'(i_result), 0);
        check("R1 valid", int'({v_valid, i_valid}), 0);
        check("R1 adc_start", int'(adc_start), 0);
        check("R1 div_sel", int'(div_sel), 0);
        check("R1 once bits", int'({v_once_busy, i_once_busy}), 0);

        // R2 range pass-through, no conversion
        s = n_start;
        do_cmd(5'b10000);
        check("R2 div_sel high", int'(div_sel), 1);
        idle(10);
        check("R2 no conversion", n_start - s, 0);
        do_cmd(5'b00000);
        check("R2 div_sel low", int'(div_sel), 0);

        // R3 voltage one-shot
        chk_order = 1'b1;
        exp_ch_q.push_back(1'b0);
        s = n_start;
        do_cmd(5'b00010);
        check("R3 once pending", int'(v_once_busy), 1);
        check("R7 valid low before result", int'(v_valid), 0);
        idle(30);
        check("R3 one start", n_start - s, 1);
        check("R3 once cleared", int'(v_once_busy), 0);
        check("R3 v_valid", int'(v_valid), 1);
        check("R3 i_valid stays low", int'(i_valid), 0);

        // R4 both one-shot, voltage then current
        exp_ch_q.push_back(1'b0); exp_ch_q.push_back(1'b1);
        s = n_start;
        do_cmd(5'b01010);
        idle(40);
        check("R4 two starts", n_start - s, 2);
        check("R4 both valid", int'({v_valid, i_valid}), 3);
        check("R4 once cleared", int'({v_once_busy, i_once_busy}), 0);
        check("R4 order queue drained", exp_ch_q.size(), 0);

        // R6 convert pin: one pass per rising edge
        exp_ch_q.push_back(1'b0); exp_ch_q.push_back(1'b1);
        s = n_start;
        conv_pin = 1'b1;
        idle(40);
        check("R6 one pass while high", n_start - s, 2);
        conv_pin = 1'b0;
        idle(10);
        check("R6 no repeat", n_start - s, 2);
        check("R6 pass order drained", exp_ch_q.size(), 0);

        // R8 read-busy defers the write
        snap = v_result;
        v_rd_busy = 1'b1;
        exp_ch_q.push_back(1'b0);
        do_cmd(5'b00010);
        idle(30);
        check("R8 result held", int'(v_result), int'(snap));
        check("R8 valid waits", int'(v_valid), 0);
        v_rd_busy = 1'b0;
        idle(10);
        check("R8 delivered after release", int'(v_valid), 1);
        check("R8 new value", int'(v_result != snap), 1);

        // R9 write while result awaits latch
        v_rd_busy = 1'b1;
        exp_ch_q.push_back(1'b0);
        s = n_start;
        do_cmd(5'b00010);
        idle(30);
        snap = v_result;
        do_cmd(5'b00000);
        v_rd_busy = 1'b0;
        idle(20);
        check("R9 discarded result", int'(v_result), int'(snap));
        check("R9 valid stays low", int'(v_valid), 0);
        check("R9 one start", n_start - s, 1);

        // R9 write in the same cycle as adc_done
        snap = v_result;
        collide_val = 5'b00010; collide_arm = 1'b1;
        exp_ch_q.push_back(1'b0); exp_ch_q.push_back(1'b0);
        s = n_start;
        do_cmd(5'b00010);
        idle(50);
        check("R9 collision restarts", n_start - s, 2);
        check("R9 fresh result valid", int'(v_valid), 1);
        check("R9 scoreboard drained", res_q.size(), 0);
        check("R9 order drained", exp_ch_q.size(), 0);

        // R5 continuous on both channels
        chk_order = 1'b0;
        n_vs = 0; n_is = 0;
        do_cmd(5'b00101);
        idle(150);
        check("R5 many voltage conversions", int'(n_vs >= 5), 1);
        check("R5 many current conversions", int'(n_is >= 5), 1);
        check("R5 alternating", int'((n_vs - n_is) <= 1 && (n_is - n_vs) <= 1), 1);
        check("R5 both valid", int'({v_valid, i_valid}), 3);
        do_cmd(5'b00000);
        check("R7 valid cleared by write", int'({v_valid, i_valid}), 0);
        idle(10);
        s = n_start;
        idle(40);
        check("R5 stopped", n_start - s, 0);
        check("R5 scoreboard drained", res_q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

endmodule